// File: doc/BRIEF.md
# Dual-Bridge Fixed-Frequency PWM Current Chopper

This block limits the peak current in two motor bridges by gating each bridge's high-side (source) drive. A single period counter runs at a fixed rate and opens both bridges at the start of every period. Each bridge then carries its own set/reset enable latch. The latch closes as soon as that bridge's digitised current code reaches a threshold derived from a shared reference code. The latch stays closed until the next period start. While the current decays, it recirculates through the low side, which lies outside this block.

Switching transients after a turn-on, or after the load current reverses, would trip the comparison falsely. For this reason a blanking window masks the comparison for a programmable number of cycles after each period start. A second, longer window follows each direction-change pulse. Other logic can override the chopper. A global disable forces both enables high. A per-bridge brake flag forces that bridge's enable high, so that the bridge logic downstream can apply the brake unhindered.

Top module: `dual_bridge_chopper`

## Requirements
- R1: In the cycle after a period start, the period counter has set every bridge's enable (`src_en` bit = 1).
- R2: A bridge's trip threshold is `ref_code` shifted right by two bits (bits [CODE_W-1:2]). A bridge trips when its sense code is equal to or greater than the threshold; a code one below the threshold never trips. A sense code that reaches the threshold in cycle n drops that bridge's enable in cycle n+2, unless blanking or an override applies.
- R3: A trip clears only the bridge whose own sense code reached the threshold.
- R4: Trips are ignored during the first BLANK_CYC cycles of every period, counted from the cycle in which the enable is set, and also after reset.
- R5: A one-cycle `dir_pulse` on a bridge masks that bridge's trips for DIR_BLANK_CYC cycles, starting in the cycle after the pulse.
- R6: The period is `tmr_count` + BLANK_CYC clock cycles long.
- R7: If a trip and a period start fall in the same cycle, the set wins, and a new blanking window begins.
- R8: While `chop_off` is high, both enables are high from the following cycle on.
- R9: While a bridge's `brake` bit is high, that bridge's enable is high from the following cycle on, whatever its sense code.
- R10: After reset both enables are high and the period counter is at zero, so the first period start follows one full period after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_count | input | CNT_W | Timing part of the period, in cycles |
| ref_code | input | CODE_W | Reference code; the threshold is this code divided by four |
| sense_code | input | NB*CODE_W | Per-bridge current codes; bridge i is in slice [i*CODE_W +: CODE_W] |
| chop_off | input | 1 | Global disable of current control; holds all enables high |
| brake | input | NB | Per-bridge brake flag; holds that enable high |
| dir_pulse | input | NB | Per-bridge one-cycle pulse on a polarity change |
| src_en | output | NB | Per-bridge source-enable latch state |

## Verification
The assertions take for granted that `dir_pulse` bits are single-cycle strobes, that `tmr_count` is at least one and stays constant during a run, and that the sense and reference codes are already synchronous to `clk`. The check that links a falling enable to a sense code two cycles earlier assumes that the reference does not change inside that window. The stimulus holds `tmr_count` fixed and fixes the reference before the first trip. It changes inputs only just after a rising edge and raises each direction pulse for exactly one cycle. The closing phase feeds back a current code that ramps up while the enable is high and down while it is low.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the dual-bridge current chopper.
// Assumes: nothing beyond standard SystemVerilog packed structs.
package chop_pkg;

    // Per-lane control from the shared top-level logic.
    typedef struct packed {
        logic set;   // period start: open the source enable
        logic hold;  // override (disable or brake): keep the enable open
    } lane_ctl_t;

endpackage

// File: rtl/chop_period_gen.sv
`timescale 1ns/1ps
// Module: chop_period_gen
// Free-running period counter shared by all bridges. It issues a one-cycle
// per_tick in the last cycle of each period, so a period is tmr_count plus
// BLANK_CYC cycles long.
// Assumes: tmr_count >= 1. If tmr_count shrinks mid-period, the counter
// ends the period at once instead of wrapping through the full range.
module chop_period_gen #(
    parameter int CNT_W     = 12,
    parameter int BLANK_CYC = 65
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_count,
    output logic             per_tick
);
    localparam int PW = CNT_W + 1;

    logic [PW-1:0] cnt;
    logic [PW-1:0] last_idx;

    // Index of the final cycle in the period.
    always_comb begin
        last_idx = PW'(tmr_count) + PW'(BLANK_CYC) - PW'(1);
    end

    assign per_tick = (cnt >= last_idx);

    // Count cycles inside the period; restart at zero after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (per_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PW'(1);
        end
    end

endmodule

// File: rtl/chop_hold_timer.sv
`timescale 1ns/1ps
// Module: chop_hold_timer
// Retriggerable down-counter. A load makes busy high for exactly LEN cycles,
// starting in the following cycle. START_FULL selects whether the window is
// already running when reset is released.
// Assumes: LEN >= 1.
module chop_hold_timer #(
    parameter int LEN        = 65,
    parameter bit START_FULL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] remain;

    // Reload on request; otherwise run down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= START_FULL ? CW'(LEN) : '0;
        end else if (load) begin
            remain <= CW'(LEN);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/chop_lane.sv
`timescale 1ns/1ps
// Module: chop_lane
// One bridge's part of the chopper: a registered magnitude compare, two
// blanking timers (turn-on and polarity change) and the set/reset
// source-enable latch. Set and hold take priority over a trip.
// Assumes: sense and thr share width CODE_W; dir_pulse is a one-cycle strobe.
module chop_lane
    import chop_pkg::*;
#(
    parameter int CODE_W        = 10,
    parameter int BLANK_CYC     = 65,
    parameter int DIR_BLANK_CYC = 90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lane_ctl_t         ctl,
    input  logic [CODE_W-1:0] sense,
    input  logic [CODE_W-1:0] thr,
    input  logic              dir_pulse,
    output logic              src_en,
    output logic              blanking
);
    logic trip_q;
    logic on_blank;
    logic dir_blank;
    logic latch_q;

    // Blanking after each turn-on; it is already running out of reset.
    chop_hold_timer #(
        .LEN        (BLANK_CYC),
        .START_FULL (1'b1)
    ) u_on_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctl.set),
        .busy  (on_blank)
    );

    // Blanking after a load-current polarity change.
    chop_hold_timer #(
        .LEN        (DIR_BLANK_CYC),
        .START_FULL (1'b0)
    ) u_dir_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dir_pulse),
        .busy  (dir_blank)
    );

    assign blanking = on_blank | dir_blank;

    // Register the magnitude comparison to keep the latch input shallow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_q <= 1'b0;
        end else begin
            trip_q <= (sense >= thr);
        end
    end

    // Source-enable latch: set or hold wins over a trip; trips are masked while blanked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b1;
        end else if (ctl.set || ctl.hold) begin
            latch_q <= 1'b1;
        end else if (trip_q && !blanking) begin
            latch_q <= 1'b0;
        end
    end

    assign src_en = latch_q;

endmodule

// File: rtl/dual_bridge_chopper.sv
`timescale 1ns/1ps
// Module: dual_bridge_chopper (top)
// Fixed-frequency peak-current chopper for NB bridges. One period counter
// opens every bridge's source enable; each bridge closes independently when
// its sense code reaches ref_code/4, outside its blanking windows.
// Assumes: CODE_W >= 3; inputs are synchronous to clk.
module dual_bridge_chopper
    import chop_pkg::*;
#(
    parameter int NB            = 2,
    parameter int CODE_W        = 10,
    parameter int CNT_W         = 12,
    parameter int BLANK_CYC     = 65,
    parameter int DIR_BLANK_CYC = 90
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     tmr_count,
    input  logic [CODE_W-1:0]    ref_code,
    input  logic [NB*CODE_W-1:0] sense_code,
    input  logic                 chop_off,
    input  logic [NB-1:0]        brake,
    input  logic [NB-1:0]        dir_pulse,
    output logic [NB-1:0]        src_en
);
    logic              per_tick;
    logic [NB-1:0]     lane_blank;
    logic [CODE_W-1:0] thr;

    // Threshold is the reference divided by four.
    assign thr = {2'b00, ref_code[CODE_W-1:2]};

    chop_period_gen #(
        .CNT_W     (CNT_W),
        .BLANK_CYC (BLANK_CYC)
    ) u_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_count (tmr_count),
        .per_tick  (per_tick)
    );

    for (genvar gi = 0; gi < NB; gi++) begin : g_lane
        lane_ctl_t ctl;
        assign ctl.set  = per_tick;
        assign ctl.hold = chop_off | brake[gi];

        chop_lane #(
            .CODE_W        (CODE_W),
            .BLANK_CYC     (BLANK_CYC),
            .DIR_BLANK_CYC (DIR_BLANK_CYC)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl       (ctl),
            .sense     (sense_code[gi*CODE_W +: CODE_W]),
            .thr       (thr),
            .dir_pulse (dir_pulse[gi]),
            .src_en    (src_en[gi]),
            .blanking  (lane_blank[gi])
        );
    end

endmodule

// File: rtl/chop_checker.sv
`timescale 1ns/1ps
// Module: chop_checker
// Property checks for dual_bridge_chopper, attached by bind below.
// Assumes: ref_code is steady across the two cycles before any trip.
module chop_checker #(
    parameter int NB     = 2,
    parameter int CODE_W = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 per_tick,
    input logic                 chop_off,
    input logic [NB-1:0]        brake,
    input logic [NB*CODE_W-1:0] sense_code,
    input logic [CODE_W-1:0]    ref_code,
    input logic [NB-1:0]        src_en,
    input logic [NB-1:0]        lane_blank
);
    logic [CODE_W-1:0] thr_ref;
    logic [NB-1:0]     at_thr;

    assign thr_ref = ref_code >> 2;

    for (genvar gi = 0; gi < NB; gi++) begin : g_chk
        assign at_thr[gi] = (sense_code[gi*CODE_W +: CODE_W] >= thr_ref);

        p_set_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
            per_tick |=> src_en[gi])
            else $error("R1 enable not set after period start, lane %0d", gi);

        p_trip_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(src_en[gi]) |-> $past(at_thr[gi], 2))
            else $error("R2 enable fell without threshold reached, lane %0d", gi);

        p_no_clear_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(src_en[gi]) |-> !$past(lane_blank[gi]))
            else $error("R4 enable cleared inside blanking, lane %0d", gi);

        p_blank_on_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            per_tick |=> lane_blank[gi])
            else $error("R7 no blanking after period start, lane %0d", gi);

        p_disable_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            chop_off |=> src_en[gi])
            else $error("R8 enable low under global disable, lane %0d", gi);

        p_brake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            brake[gi] |=> src_en[gi])
            else $error("R9 enable low under brake, lane %0d", gi);
    end

endmodule

bind dual_bridge_chopper chop_checker #(
    .NB     (NB),
    .CODE_W (CODE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .per_tick   (per_tick),
    .chop_off   (chop_off),
    .brake      (brake),
    .sense_code (sense_code),
    .ref_code   (ref_code),
    .src_en     (src_en),
    .lane_blank (lane_blank)
);

// File: tb/dual_bridge_chopper_test.sv
`timescale 1ns/1ps
// Directed bench: a cycle index counts from the first cycle after reset.
// P = 20 + 4 = 24 cycles per period; threshold = 403 >> 2 = 100.
module dual_bridge_chopper_test;
    localparam int NB   = 2;
    localparam int CW   = 10;
    localparam int B    = 4;
    localparam int D    = 6;
    localparam int TMR  = 20;
    localparam int P    = TMR + B;
    localparam int THR  = 100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      tmr_count = 8'(TMR);
    logic [CW-1:0]   ref_code = 10'd403;
    logic [CW-1:0]   sense_a = '0;
    logic [CW-1:0]   sense_b = '0;
    logic            chop_off = 1'b0;
    logic [NB-1:0]   brake = '0;
    logic [NB-1:0]   dir_pulse = '0;
    logic [NB-1:0]   src_en;
    int              cyc = 0;
    int              compared = 0;
    int              mismatched = 0;

    dual_bridge_chopper #(
        .NB            (NB),
        .CODE_W        (CW),
        .CNT_W         (8),
        .BLANK_CYC     (B),
        .DIR_BLANK_CYC (D)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_count  (tmr_count),
        .ref_code   (ref_code),
        .sense_code ({sense_b, sense_a}),
        .chop_off   (chop_off),
        .brake      (brake),
        .dir_pulse  (dir_pulse),
        .src_en     (src_en)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic wait_cycle(input int n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check_en(input int n, input logic [1:0] exp, input logic [1:0] mask,
                            input string tag);
        wait_cycle(n);
        @(negedge clk);
        compared++;
        if ((src_en & mask) !== (exp & mask)) begin
            mismatched++;
            $display("FAIL %s cycle %0d: src_en=%b expected %b (mask %b)",
                     tag, n, src_en, exp, mask);
        end
    endtask

    task automatic check_true(input bit ok, input string tag, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic t_reset();
        check_en(0, 2'b11, 2'b11, "R10 reset state");
        check_en(2, 2'b11, 2'b11, "R10 held while blanked after reset");
    endtask

    task automatic t_trip_after_blank(input int s);
        wait_cycle(s);
        sense_a = 10'(THR);
        check_en(s + B,     2'b01, 2'b01, "R4 trip masked in turn-on blanking");
        check_en(s + B + 1, 2'b00, 2'b01, "R2 clear two cycles after sense at threshold");
        check_en(s + B + 1, 2'b10, 2'b10, "R3 other bridge untouched");
        wait_cycle(s + 6);
        sense_a = '0;
        check_en(s + P - 1, 2'b00, 2'b01, "R6 still cleared in last cycle of period");
        check_en(s + P,     2'b01, 2'b01, "R1 set at period start (R6 length)");
    endtask

    task automatic t_below(input int s);
        wait_cycle(s);
        sense_a = 10'(THR - 1);
        sense_b = 10'(THR - 1);
        wait_cycle(s + P - 2);
        sense_a = '0;
        sense_b = '0;
        check_en(s + P - 1, 2'b11, 2'b11, "R2 code one below threshold never trips");
    endtask

    task automatic t_dir_blank(input int s);
        wait_cycle(s + 2);
        dir_pulse = 2'b01;
        wait_cycle(s + 3);
        dir_pulse = 2'b00;
        wait_cycle(s + 4);
        sense_a = 10'(THR);
        check_en(s + 9,  2'b01, 2'b01, "R5 trip masked by direction blanking");
        check_en(s + 10, 2'b00, 2'b01, "R5 trip honoured after direction blanking");
    endtask

    task automatic t_set_wins(input int s);
        check_en(s,         2'b01, 2'b01, "R7 set wins over trip at period start");
        check_en(s + B,     2'b01, 2'b01, "R7 blanking restarted after set");
        check_en(s + B + 1, 2'b00, 2'b01, "R7 trip after restarted blanking");
        wait_cycle(s + 6);
        sense_a = '0;
    endtask

    task automatic t_disable(input int s);
        wait_cycle(s);
        sense_a = 10'(THR);
        check_en(s + B + 1, 2'b00, 2'b01, "R2 cleared before disable");
        wait_cycle(s + 6);
        chop_off = 1'b1;
        check_en(s + 7,  2'b11, 2'b11, "R8 disable forces both enables");
        check_en(s + 15, 2'b11, 2'b11, "R8 disable holds despite trip");
        wait_cycle(s + 17);
        sense_a = '0;
        wait_cycle(s + 21);
        chop_off = 1'b0;
        check_en(s + 22, 2'b11, 2'b11, "R8 enables high after release");
    endtask

    task automatic t_brake(input int s);
        wait_cycle(s);
        sense_a = 10'(THR);
        sense_b = 10'(THR + 50);
        brake   = 2'b10;
        check_en(s + B + 1, 2'b10, 2'b11, "R9 braked bridge held, other trips (R3)");
        check_en(s + 16,    2'b10, 2'b10, "R9 braked bridge still held");
        wait_cycle(s + 15);
        sense_b = '0;
        sense_a = '0;
        wait_cycle(s + 18);
        brake = 2'b00;
        check_en(s + 19, 2'b10, 2'b10, "R9 enable kept after brake release");
    endtask

    task automatic t_ramp(input int first, input int last);
        int hist_a[512];
        int hist_b[512];
        int cur_a = 0;
        int cur_b = 0;
        int falls_a = 0;
        int falls_b = 0;
        logic [1:0] prev = 2'b00;
        logic [1:0] now_en;
        for (int i = 0; i < 512; i++) begin
            hist_a[i] = 0;
            hist_b[i] = 0;
        end
        for (int n = first; n <= last; n++) begin
            wait_cycle(n);
            sense_a = 10'(cur_a);
            sense_b = 10'(cur_b);
            hist_a[n] = cur_a;
            hist_b[n] = cur_b;
            @(negedge clk);
            now_en = src_en;
            if (n % P == 0)
                check_true(now_en == 2'b11, "R1 both set at ramp period start",
                           int'(now_en), 3);
            if (prev[0] && !now_en[0]) begin
                falls_a++;
                check_true(hist_a[n-2] >= THR && ((n-1) % P) >= B && ((n-1) % P) != P-1,
                           "R4 bridge A fall only outside blanking and at threshold (R2)",
                           hist_a[n-2], THR);
            end
            if (prev[1] && !now_en[1]) begin
                falls_b++;
                check_true(hist_b[n-2] >= THR && ((n-1) % P) >= B && ((n-1) % P) != P-1,
                           "R4 bridge B fall only outside blanking and at threshold (R2)",
                           hist_b[n-2], THR);
            end
            cur_a = now_en[0] ? cur_a + 7  : cur_a - 2;
            cur_b = now_en[1] ? cur_b + 11 : cur_b - 2;
            if (cur_a < 0) cur_a = 0;
            if (cur_b < 0) cur_b = 0;
            if (cur_a > 1023) cur_a = 1023;
            if (cur_b > 1023) cur_b = 1023;
            prev = now_en;
        end
        check_true(falls_a >= 5, "R3 bridge A chops each period", falls_a, 5);
        check_true(falls_b >= 5, "R3 bridge B chops each period", falls_b, 5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // cycle 0 now running: counter at zero, enables set
        t_reset();
        t_trip_after_blank(1 * P);
        t_below(2 * P);
        t_dir_blank(3 * P);
        t_set_wins(4 * P);
        t_disable(5 * P);
        t_brake(6 * P);
        t_ramp(7 * P, 13 * P - 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2_000_000;
        compared++;
        mismatched++;
        $display("FAIL watchdog: run stalled at cycle %0d, expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule